// File: doc/BRIEF.md
# Interrupt Cause and Mask Aggregator

This block gathers 29 event sources from a system controller (address range faults, DMA channel completions, timer expiries, PCI error and abort events, external CPU interrupt pins and PCI interrupt pins). Each source is captured into a sticky bit of a 32-bit cause register. A 32-bit mask register qualifies those bits. The block reports which qualified source has the highest priority and drives one CPU interrupt request.

Software reads and writes the two registers over a single-cycle register port. To acknowledge a source, software writes a word with a zero in that source's position and ones everywhere else. Three positions of the cause word hold no event of their own. They read back as OR summaries over fixed groups of event bits, so a handler can tell with one read which family of sources needs attention.

Top module: `irq_cause_agg`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the cause word and the mask word both read as 0, the valid flag is 0 and the CPU request is 0.
- R2: Input `evt_in[k]` that is high at a rising clock edge sets cause bit k+1. The bit stays set after the input falls, until software clears it.
- R3: A write with `bus_sel`=0 clears every cause bit in positions 1 to 29 whose write data bit is 0. Bits written as 1 keep their value.
- R4: If a source's event is high in the same cycle as a write that clears its bit, the bit remains set.
- R5: Cause read bit 0 equals the OR of cause bits 29 down to 1.
- R6: Cause read bit 30 equals the OR of cause bits 29 down to 26 and bits 20 down to 1.
- R7: Cause read bit 31 equals the OR of cause bits 25 down to 1.
- R8: The summary bits 0, 30 and 31 are formed from the latched cause bits without regard to the mask. Write data in those three positions has no effect on the cause word.
- R9: A write with `bus_sel`=1 loads all 32 bits of the mask word, and a read with `bus_sel`=1 returns it. A source counts as pending only when both its cause bit and its mask bit are 1.
- R10: `pend_idx` gives the lowest-numbered pending position among bits 1 to 29, with `pend_valid`=1. When no source is pending, `pend_valid` is 0.
- R11: `cpu_irq` is high in a cycle exactly when at least one source was pending in the previous cycle. It is the OR of the pending bits, delayed by one register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_in | input | 29 | Event sources; bit k feeds cause bit k+1 |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_sel | input | 1 | Register select: 0 = cause, 1 = mask |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register (combinational) |
| pend_idx | output | 5 | Bit position of the highest-priority pending source |
| pend_valid | output | 1 | High when any source is pending |
| cpu_irq | output | 1 | Registered CPU interrupt request |

## Verification
The bench targets a clear that lands in the same cycle as its own event. A design that gives the write priority would drop that event, and the cause bit would read 0 one cycle later. It also raises single sources at bits 20, 22 and 27, which sit at the edges of the irregular summary groups. A summary slice that is one bit off would then show the wrong pattern in bits 30 and 31. The bench writes ones into the summary positions and checks that those writes neither alter cause reads nor leak into the event bits. It unmasks sources in pairs to check that the lower index wins and that the request goes high one cycle after the pending set becomes non-empty, not in the same cycle.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

   // Register select encoding on the register port
   typedef enum logic {
      SEL_CAUSE = 1'b0,
      SEL_MASK  = 1'b1
   } irq_reg_sel_e;

   // Default word geometry
   localparam int unsigned WORD_W   = 32;
   localparam int unsigned EVT_LO   = 1;
   localparam int unsigned EVT_HI   = 29;

   // Summary positions and the groups they cover
   localparam int unsigned SUM_ALL_POS = 0;
   localparam int unsigned SUM_A_POS   = 30;
   localparam int unsigned SUM_B_POS   = 31;
   localparam int unsigned GA1_HI = 29;
   localparam int unsigned GA1_LO = 26;
   localparam int unsigned GA2_HI = 20;
   localparam int unsigned GA2_LO = 1;
   localparam int unsigned GB_HI  = 25;
   localparam int unsigned GB_LO  = 1;

endpackage

// File: rtl/irq_cause_store.sv
module irq_cause_store #(
   parameter int unsigned LO = 1,
   parameter int unsigned HI = 29
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [HI:LO]  evt,
   input  logic          clr_en,
   input  logic [HI:LO]  keep_bits,
   output logic [HI:LO]  cause_q
);

   logic [HI:LO] survive;

   // Writing zero drops a bit; writing one keeps it
   always_comb begin
      survive = clr_en ? (cause_q & keep_bits) : cause_q;
   end

   // New events are ORed in after the clear, so they win
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cause_q <= '0;
      end else begin
         cause_q <= survive | evt;
      end
   end

endmodule

// File: rtl/irq_summary.sv
module irq_summary #(
   parameter int unsigned LO     = 1,
   parameter int unsigned HI     = 29,
   parameter int unsigned A1_HI  = 29,
   parameter int unsigned A1_LO  = 26,
   parameter int unsigned A2_HI  = 20,
   parameter int unsigned A2_LO  = 1,
   parameter int unsigned B_HI   = 25,
   parameter int unsigned B_LO   = 1
) (
   input  logic [HI:LO] cause_i,
   output logic         sum_all,
   output logic         sum_a,
   output logic         sum_b
);

   if (A1_HI > HI || A1_LO < LO || A1_LO > A1_HI) begin : g_bad_a1
      $error("irq_summary: group A1 outside event range");
   end
   if (A2_HI > HI || A2_LO < LO || A2_LO > A2_HI) begin : g_bad_a2
      $error("irq_summary: group A2 outside event range");
   end
   if (B_HI > HI || B_LO < LO || B_LO > B_HI) begin : g_bad_b
      $error("irq_summary: group B outside event range");
   end

   always_comb begin
      sum_all = |cause_i;
      sum_a   = (|cause_i[A1_HI:A1_LO]) | (|cause_i[A2_HI:A2_LO]);
      sum_b   = |cause_i[B_HI:B_LO];
   end

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int unsigned LO        = 1,
   parameter int unsigned HI        = 29,
   parameter int unsigned IDX_W     = 5,
   parameter bit          LOW_FIRST = 1'b1
) (
   input  logic [HI:LO]      pend_i,
   output logic [IDX_W-1:0]  idx_o,
   output logic              valid_o
);

   if ((1 << IDX_W) <= HI) begin : g_bad_w
      $error("irq_prio_enc: index width too small");
   end

   if (LOW_FIRST) begin : g_low
      // Scan downward; the last hit is the lowest index
      always_comb begin
         idx_o = '0;
         for (int i = HI; i >= int'(LO); i--) begin
            if (pend_i[i]) idx_o = IDX_W'(i);
         end
      end
   end else begin : g_high
      always_comb begin
         idx_o = '0;
         for (int i = LO; i <= int'(HI); i++) begin
            if (pend_i[i]) idx_o = IDX_W'(i);
         end
      end
   end

   assign valid_o = |pend_i;

endmodule

// File: rtl/irq_cause_agg.sv
module irq_cause_agg
   import irq_agg_pkg::*;
#(
   parameter int unsigned DATA_W    = WORD_W,
   parameter int unsigned SRC_LO    = EVT_LO,
   parameter int unsigned SRC_HI    = EVT_HI,
   parameter bit          REG_IRQ   = 1'b1,
   parameter bit          LOW_FIRST = 1'b1,
   localparam int unsigned NSRC     = SRC_HI - SRC_LO + 1,
   localparam int unsigned IDX_W    = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   evt_in,
   input  logic              bus_wr,
   input  logic              bus_sel,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [IDX_W-1:0]  pend_idx,
   output logic              pend_valid,
   output logic              cpu_irq
);

   if (SRC_HI >= DATA_W || SRC_LO == 0) begin : g_bad_range
      $error("irq_cause_agg: event range must sit inside the word above bit 0");
   end
   if (SUM_A_POS >= DATA_W || SUM_B_POS >= DATA_W ||
       (SUM_A_POS >= SRC_LO && SUM_A_POS <= SRC_HI) ||
       (SUM_B_POS >= SRC_LO && SUM_B_POS <= SRC_HI)) begin : g_bad_sum
      $error("irq_cause_agg: summary position collides with event range");
   end

   logic [SRC_HI:SRC_LO] evt_w;
   logic [SRC_HI:SRC_LO] cause_q;
   logic [DATA_W-1:0]    mask_q;
   logic [SRC_HI:SRC_LO] pend;
   logic                 cause_wr;
   logic                 mask_wr;
   logic                 sum_all;
   logic                 sum_a;
   logic                 sum_b;
   logic [DATA_W-1:0]    cause_rd;

   assign evt_w    = evt_in;
   assign cause_wr = bus_wr && (bus_sel == SEL_CAUSE);
   assign mask_wr  = bus_wr && (bus_sel == SEL_MASK);

   irq_cause_store #(
      .LO (SRC_LO),
      .HI (SRC_HI)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt       (evt_w),
      .clr_en    (cause_wr),
      .keep_bits (bus_wdata[SRC_HI:SRC_LO]),
      .cause_q   (cause_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
      end else if (mask_wr) begin
         mask_q <= bus_wdata;
      end
   end

   irq_summary #(
      .LO    (SRC_LO),
      .HI    (SRC_HI),
      .A1_HI (GA1_HI),
      .A1_LO (GA1_LO),
      .A2_HI (GA2_HI),
      .A2_LO (GA2_LO),
      .B_HI  (GB_HI),
      .B_LO  (GB_LO)
   ) u_sum (
      .cause_i (cause_q),
      .sum_all (sum_all),
      .sum_a   (sum_a),
      .sum_b   (sum_b)
   );

   assign pend = cause_q & mask_q[SRC_HI:SRC_LO];

   irq_prio_enc #(
      .LO        (SRC_LO),
      .HI        (SRC_HI),
      .IDX_W     (IDX_W),
      .LOW_FIRST (LOW_FIRST)
   ) u_prio (
      .pend_i  (pend),
      .idx_o   (pend_idx),
      .valid_o (pend_valid)
   );

   always_comb begin
      cause_rd                 = '0;
      cause_rd[SRC_HI:SRC_LO]  = cause_q;
      cause_rd[SUM_ALL_POS]    = sum_all;
      cause_rd[SUM_A_POS]      = sum_a;
      cause_rd[SUM_B_POS]      = sum_b;
   end

   assign bus_rdata = (bus_sel == SEL_MASK) ? mask_q : cause_rd;

   if (REG_IRQ) begin : g_irq_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cpu_irq <= 1'b0;
         end else begin
            cpu_irq <= |pend;
         end
      end
   end else begin : g_irq_comb
      assign cpu_irq = |pend;
   end

endmodule

// File: rtl/irq_cause_agg_chk.sv
module irq_cause_agg_chk #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned SRC_LO  = 1,
   parameter int unsigned SRC_HI  = 29,
   parameter int unsigned IDX_W   = 5,
   parameter bit          REG_IRQ = 1'b1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [SRC_HI-SRC_LO:0] evt_in,
   input logic                 bus_wr,
   input logic                 bus_sel,
   input logic [DATA_W-1:0]    bus_wdata,
   input logic [DATA_W-1:0]    bus_rdata,
   input logic [IDX_W-1:0]     pend_idx,
   input logic                 pend_valid,
   input logic                 cpu_irq,
   input logic [SRC_HI:SRC_LO] cause_q,
   input logic [DATA_W-1:0]    mask_q
);

   logic [SRC_HI:SRC_LO] pend_c;
   logic [SRC_HI:SRC_LO] evt_c;
   assign pend_c = cause_q & mask_q[SRC_HI:SRC_LO];
   assign evt_c  = evt_in;

   // R2 / R4: every event seen at an edge is present in the cause bits after it
   assert_evt_captured_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_c) |=> ((cause_q & $past(evt_c)) == $past(evt_c)));

   // R3: a bit written as zero without a same-cycle event is gone next cycle
   assert_zero_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_sel) |=>
         ((cause_q & ~$past(bus_wdata[SRC_HI:SRC_LO]) & ~$past(evt_c)) == '0));

   // R5: summary of all events on the cause read port
   assert_sum_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_sel) |-> (bus_rdata[0] == (|bus_rdata[SRC_HI:SRC_LO])));

   // R9: mask write lands in the mask word
   assert_mask_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_sel) |=> (mask_q == $past(bus_wdata)));

   // R10: the reported source is really pending, and none means invalid
   assert_idx_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pend_valid |-> (cause_q[pend_idx] && mask_q[pend_idx]));
   assert_none_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_valid) |-> (pend_c == '0));

   if (REG_IRQ) begin : g_irq_chk
      // R11: the request follows the pending set by one cycle
      assert_irq_lag_R11: assert property (@(posedge clk) disable iff (!rst_n)
         cpu_irq == $past(|pend_c));
   end

endmodule

bind irq_cause_agg irq_cause_agg_chk #(
   .DATA_W  (DATA_W),
   .SRC_LO  (SRC_LO),
   .SRC_HI  (SRC_HI),
   .IDX_W   (IDX_W),
   .REG_IRQ (REG_IRQ)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .evt_in     (evt_in),
   .bus_wr     (bus_wr),
   .bus_sel    (bus_sel),
   .bus_wdata  (bus_wdata),
   .bus_rdata  (bus_rdata),
   .pend_idx   (pend_idx),
   .pend_valid (pend_valid),
   .cpu_irq    (cpu_irq),
   .cause_q    (cause_q),
   .mask_q     (mask_q)
);

// File: tb/irq_cause_agg_tb.sv
`timescale 1ns/1ps
module irq_cause_agg_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [28:0] evt_in = '0;
   logic        bus_wr = 1'b0;
   logic        bus_sel = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [4:0]  pend_idx;
   logic        pend_valid;
   logic        cpu_irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // reference state
   bit [31:0] m_cause = '0;  // only bits 29:1 meaningful
   bit [31:0] m_mask  = '0;
   bit        m_irq   = 0;

   always #10 clk = ~clk;

   irq_cause_agg u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_in     (evt_in),
      .bus_wr     (bus_wr),
      .bus_sel    (bus_sel),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .pend_idx   (pend_idx),
      .pend_valid (pend_valid),
      .cpu_irq    (cpu_irq)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic bit any_in(input bit [31:0] v, input int hi, input int lo);
      bit r = 0;
      for (int i = lo; i <= hi; i++) r |= v[i];
      return r;
   endfunction

   function automatic bit [31:0] exp_cause_word();
      bit [31:0] w = '0;
      for (int i = 1; i <= 29; i++) w[i] = m_cause[i];
      w[0]  = any_in(m_cause, 29, 1);
      w[30] = any_in(m_cause, 29, 26) | any_in(m_cause, 20, 1);
      w[31] = any_in(m_cause, 25, 1);
      return w;
   endfunction

   task automatic compare_all(input string req);
      int  lo_idx = 0;
      bit  any = 0;
      for (int i = 29; i >= 1; i--) begin
         if (m_cause[i] && m_mask[i]) begin
            lo_idx = i;
            any = 1;
         end
      end
      if (bus_sel) chk(req, "mask read", bus_rdata, m_mask);
      else         chk(req, "cause read", bus_rdata, exp_cause_word());
      chk("R10", "valid", {31'd0, pend_valid}, {31'd0, any});
      if (any) chk("R10", "index", {27'd0, pend_idx}, lo_idx);
      chk("R11", "cpu_irq", {31'd0, cpu_irq}, {31'd0, m_irq});
   endtask

   // one clock: drive, let the edge happen, update reference, compare
   task automatic cyc(input string req, input logic [28:0] ev, input logic wr,
                      input logic sel, input logic [31:0] wd);
      evt_in    = ev;
      bus_wr    = wr;
      bus_sel   = sel;
      bus_wdata = wd;
      @(posedge clk);
      begin
         bit p = 0;
         for (int i = 1; i <= 29; i++) p |= m_cause[i] & m_mask[i];
         m_irq = p;
      end
      if (wr && !sel) begin
         for (int i = 1; i <= 29; i++) m_cause[i] = m_cause[i] & wd[i];
      end
      for (int i = 1; i <= 29; i++) m_cause[i] = m_cause[i] | ev[i-1];
      if (wr && sel) m_mask = wd;
      @(negedge clk);
      evt_in = '0;
      bus_wr = 1'b0;
      compare_all(req);
   endtask

   // read one register without changing state
   task automatic peek(input string req, input logic sel);
      cyc(req, '0, 1'b0, sel, '0);
   endtask

   initial begin
      int cnt = 0;
      while (!done) begin
         @(posedge clk);
         cnt++;
         if (cnt > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      // R1: values during reset
      repeat (3) @(negedge clk);
      bus_sel = 1'b0; #1;
      chk("R1", "cause in reset", bus_rdata, 32'h0);
      bus_sel = 1'b1; #1;
      chk("R1", "mask in reset", bus_rdata, 32'h0);
      chk("R1", "valid in reset", {31'd0, pend_valid}, 32'd0);
      chk("R1", "irq in reset", {31'd0, cpu_irq}, 32'd0);
      rst_n = 1'b1;
      peek("R1", 1'b0);
      peek("R1", 1'b1);

      // R2: capture and hold while masked
      cyc("R2", 29'h1 << 4, 1'b0, 1'b0, '0);   // cause bit 5
      peek("R2", 1'b0);
      cyc("R2", 29'h1 << 27, 1'b0, 1'b0, '0);  // cause bit 28
      peek("R2", 1'b0);

      // R9: mask load and readback, pending appears
      cyc("R9", '0, 1'b1, 1'b1, 32'hA5A5_5A5A);
      peek("R9", 1'b1);
      cyc("R9", '0, 1'b1, 1'b1, 32'hFFFF_FFFF);
      peek("R10", 1'b0);
      peek("R11", 1'b0);

      // R3: clear bit 5 only, bit 28 stays
      cyc("R3", '0, 1'b1, 1'b0, ~(32'h1 << 5));
      peek("R3", 1'b0);
      cyc("R3", '0, 1'b1, 1'b0, 32'h0);
      peek("R11", 1'b0);
      peek("R11", 1'b0);

      // R4: event and its clear in the same cycle
      cyc("R4", 29'h1 << 9, 1'b0, 1'b0, '0);           // bit 10
      cyc("R4", 29'h1 << 9, 1'b1, 1'b0, ~(32'h1 << 10));
      peek("R4", 1'b0);

      // R8: ones written into summary slots change nothing
      cyc("R8", '0, 1'b1, 1'b0, 32'hFFFF_FFFF);
      peek("R8", 1'b0);
      cyc("R8", '0, 1'b1, 1'b0, 32'hC000_0001 | ~(32'h1 << 10));
      peek("R8", 1'b0);
      // summaries ignore the mask
      cyc("R8", '0, 1'b1, 1'b1, 32'h0);
      cyc("R8", 29'h1 << 2, 1'b0, 1'b0, '0);
      peek("R8", 1'b0);
      cyc("R8", '0, 1'b1, 1'b0, 32'h0);

      // R6 / R7 / R5: group boundaries
      cyc("R6", 29'h1 << 26, 1'b0, 1'b0, '0);  // bit 27 only: A=1 B=0
      peek("R6", 1'b0);
      cyc("R6", '0, 1'b1, 1'b0, 32'h0);
      cyc("R7", 29'h1 << 21, 1'b0, 1'b0, '0);  // bit 22 only: A=0 B=1
      peek("R7", 1'b0);
      cyc("R7", '0, 1'b1, 1'b0, 32'h0);
      cyc("R5", 29'h1 << 19, 1'b0, 1'b0, '0);  // bit 20: both
      peek("R5", 1'b0);
      cyc("R7", 29'h1 << 24, 1'b0, 1'b0, '0);  // bit 25 joins
      cyc("R5", '0, 1'b1, 1'b0, 32'h0);
      peek("R5", 1'b0);

      // R10: priority between pairs
      cyc("R10", (29'h1 << 16) | (29'h1 << 6), 1'b1, 1'b1, 32'h0002_0000);
      peek("R10", 1'b0);                       // only bit 17 unmasked
      cyc("R10", '0, 1'b1, 1'b1, 32'h0002_0080);
      peek("R10", 1'b0);                       // bit 7 wins
      cyc("R10", '0, 1'b1, 1'b0, ~(32'h1 << 7));
      peek("R10", 1'b0);
      peek("R11", 1'b0);
      cyc("R11", '0, 1'b1, 1'b0, 32'h0);
      peek("R11", 1'b0);

      // mixed traffic
      for (int n = 0; n < 400; n++) begin
         logic [28:0] ev = ($urandom % 3 == 0) ? 29'($urandom) & 29'($urandom) : '0;
         logic wr  = ($urandom % 4) == 0;
         logic sel = ($urandom % 2) == 1;
         logic [31:0] wd = $urandom | $urandom;
         cyc("R2", ev, wr, sel, wd);
      end

      // R1: reset in mid-run clears everything
      @(negedge clk);
      rst_n = 1'b0;
      m_cause = '0; m_mask = '0; m_irq = 0;
      @(negedge clk);
      bus_sel = 1'b0; #1;
      chk("R1", "cause after reset", bus_rdata, 32'h0);
      bus_sel = 1'b1; #1;
      chk("R1", "mask after reset", bus_rdata, 32'h0);
      chk("R1", "irq after reset", {31'd0, cpu_irq}, 32'd0);
      rst_n = 1'b1;
      peek("R1", 1'b0);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule